// File: doc/BRIEF.md
# ECC-Protected Word-Packed Memory Front End

This block is a synchronous memory whose storage holds wide 64-bit words. Each word carries 7 check bits of a single-error-correcting Hamming code. Outside the block, the data port is one byte or one halfword wide, chosen by a static mode input. The flat 21-bit address is split into a row, a column and a byte or halfword lane inside the wide word. A narrow write becomes a read-modify-write in a single cycle: the block fetches the addressed word, repairs any single flipped bit, merges the new lane, recomputes all check bits and stores the whole word again.

Operations start on the rising clock edge. An active-low chip select enables the block, a write-enable input chooses between read and write, and an output-enable input gates the data port. A drive flag stands in for the tristate state of a real pin. The port has no handshake: the block accepts one operation on every enabled edge and never applies back-pressure. The number of rows is a parameter, so that simulation can use a small array, and row address bits above that depth alias onto lower rows. Two test inputs flip one stored bit so that correction can be exercised. A sticky flag records that a correctable error was met.

Top module: `ecc_packed_mem`

## Requirements
- R1: After reset `rdata` is 0, `err_seen` is 0, and every stored word reads back as zero data.
- R2: In byte mode (`wide_mode`=0), a write on an edge with `cs_n`=0 and `wr_en`=1 stores `wdata[7:0]` in byte lane {addr[20],addr[1:0]} of the word selected by row addr[19:8] and column addr[7:2]. Byte lane b is bits 8b+7:8b of the 64-bit word. The other seven bytes of that word keep their values.
- R3: In halfword mode (`wide_mode`=1), addr[0] is ignored and {addr[20],addr[1]} selects halfword lane h, which is bits 16h+15:16h. Halfword lane h therefore spans byte lanes 2h (low byte) and 2h+1 (high byte).
- R4: A read on an edge with `cs_n`=0 and `wr_en`=0 places the addressed lane on `rdata` from that edge onward. The value holds until the next read edge, and write or disabled cycles do not change it.
- R5: On an edge with `cs_n`=1 nothing is written and the held read value is not changed. While `cs_n`=1, `dq_drive` is 0 and `rdata` is 0.
- R6: While `out_en`=0, `dq_drive` is 0 and `rdata` is 0. The held read value appears once `out_en`=1 and `cs_n`=0.
- R7: In byte mode `rdata[15:8]` is always 0 and `wdata[15:8]` has no effect on stored data.
- R8: A read returns the correct data when any one of the 71 stored bits of the word has been flipped.
- R9: A write to a word that holds one flipped bit stores the corrected word with the new lane merged in, so all eight bytes read back as intended.
- R10: `err_seen` becomes 1 after any read or write edge whose fetched word had a nonzero syndrome. Only reset clears it, and a bit flip alone does not set it.
- R11: The array holds 2^ROW_BITS rows (default ROW_BITS=3). Row address bits at or above ROW_BITS are ignored, so row r aliases row r mod 2^ROW_BITS.
- R12: On an edge with `cs_n`=1 and `inj_en`=1, stored bit `inj_pos` (0 to 70) of the word addressed by `addr` is inverted. Bit j of the stored codeword is Hamming position j+1, and check bits sit at j = 2^k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operations start on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| out_en | input | 1 | Active-high output enable |
| wide_mode | input | 1 | 0 = byte port, 1 = halfword port (static) |
| addr | input | 21 | Flat address: row, column and lane fields |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when not driven |
| dq_drive | output | 1 | 1 when the data port would be driven |
| err_seen | output | 1 | Sticky flag: corrected error met |
| inj_en | input | 1 | Test: flip one stored bit on a disabled edge |
| inj_pos | input | 7 | Test: codeword bit to flip |

## Verification
Error correction and lane merging can fall in the same cycle. This happens when a narrow write targets a word that already carries a flipped bit. The bench provokes it by flipping a stored bit of a fully written word, checking that the flip alone leaves the flag clear, and then writing one byte into that word. It judges the result by the flag rising after the write and by all eight bytes reading back with the new byte and the original seven. Halfword writes read back byte by byte give a second cross-check on how the two port widths pack into the same word.

// File: rtl/ecc_packed_pkg.sv
package ecc_packed_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 7;
  localparam int CW_W   = DATA_W + CHK_W;

  function automatic bit is_check_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of the Hamming positions (1-based) of every set bit
  function automatic logic [CHK_W-1:0] cw_syndrome(logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw[p-1]) s = s ^ CHK_W'(p);
    return s;
  endfunction

  function automatic logic [CW_W-1:0] cw_encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0]  cw;
    logic [CHK_W-1:0] s;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    s = cw_syndrome(cw);
    for (int c = 0; c < CHK_W; c++) cw[(1 << c) - 1] = s[c];
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] cw_extract(logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_check_pos(p)) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/wp_addr_split.sv
module wp_addr_split
  import ecc_packed_pkg::*;
#(
  parameter int ROW_BITS = 3,
  localparam int COL_BITS = 6,
  localparam int IDX_W = ROW_BITS + COL_BITS
) (
  input  logic [20:0]      addr,
  input  logic             wide_mode,
  output logic [IDX_W-1:0] idx,
  output logic [2:0]       byte_sel,
  output logic [7:0]       byte_en
);
  // upper row bits are simply dropped: rows alias modulo 2^ROW_BITS
  assign idx      = {addr[8 +: ROW_BITS], addr[7:2]};
  assign byte_sel = {addr[20], addr[1], addr[0] & ~wide_mode};

  for (genvar b = 0; b < 8; b++) begin : g_be
    assign byte_en[b] = wide_mode ? (byte_sel[2:1] == 2'(b / 2))
                                  : (byte_sel == 3'(b));
  end
endmodule

// File: rtl/sec_encode.sv
module sec_encode
  import ecc_packed_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CW_W-1:0]   cw_out
);
  assign cw_out = cw_encode(data_in);
endmodule

// File: rtl/sec_correct.sv
module sec_correct
  import ecc_packed_pkg::*;
(
  input  logic [CW_W-1:0]   cw_in,
  output logic [CW_W-1:0]   cw_out,
  output logic [DATA_W-1:0] data_out,
  output logic [CHK_W-1:0]  syn_out,
  output logic              err_out
);
  always_comb begin
    syn_out = cw_syndrome(cw_in);
    cw_out  = cw_in;
    if (syn_out != '0 && int'(syn_out) <= CW_W)
      cw_out[int'(syn_out) - 1] = ~cw_in[int'(syn_out) - 1];
  end
  assign err_out  = (syn_out != '0);
  assign data_out = cw_extract(cw_out);
endmodule

// File: rtl/wp_word_store.sv
module wp_word_store
  import ecc_packed_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [CW_W-1:0]  rd_cw,
  input  logic             wr_go,
  input  logic [CW_W-1:0]  wr_cw,
  input  logic             flip_go,
  input  logic [6:0]       flip_pos
);
  logic [CW_W-1:0] mem [DEPTH];

  assign rd_cw = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_go) begin
      mem[idx] <= wr_cw;
    end else if (flip_go) begin
      mem[idx][flip_pos] <= ~mem[idx][flip_pos];
    end
  end

  AST_WRITEBACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> cw_syndrome(wr_cw) == '0);                            // R9
  AST_FLIP_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && flip_go));                                           // R12
endmodule

// File: rtl/ecc_packed_mem.sv
module ecc_packed_mem
  import ecc_packed_pkg::*;
#(
  parameter int ROW_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        wr_en,
  input  logic        out_en,
  input  logic        wide_mode,
  input  logic [20:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        dq_drive,
  output logic        err_seen,
  input  logic        inj_en,
  input  logic [6:0]  inj_pos
);
  localparam int IDX_W = ROW_BITS + 6;

  logic [IDX_W-1:0]  idx;
  logic [2:0]        bsel;
  logic [7:0]        be;
  logic [CW_W-1:0]   stored_cw, fixed_cw, new_cw;
  logic [DATA_W-1:0] old_data, merged;
  logic [CHK_W-1:0]  syn;
  logic              hit;
  logic              do_write, do_read, do_flip;
  logic [15:0]       rd_next, rd_q;
  logic              err_q;

  assign do_write = ~cs_n & wr_en;
  assign do_read  = ~cs_n & ~wr_en;
  assign do_flip  = cs_n & inj_en & (inj_pos < 7'(CW_W));

  wp_addr_split #(.ROW_BITS(ROW_BITS)) u_split (
    .addr(addr), .wide_mode(wide_mode), .idx(idx),
    .byte_sel(bsel), .byte_en(be));

  wp_word_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_cw(stored_cw),
    .wr_go(do_write), .wr_cw(new_cw), .flip_go(do_flip), .flip_pos(inj_pos));

  sec_correct u_fix (
    .cw_in(stored_cw), .cw_out(fixed_cw), .data_out(old_data),
    .syn_out(syn), .err_out(hit));

  for (genvar b = 0; b < 8; b++) begin : g_merge
    assign merged[8*b +: 8] = !be[b]    ? old_data[8*b +: 8] :
                              wide_mode ? wdata[8*(b%2) +: 8] : wdata[7:0];
  end

  sec_encode u_enc (.data_in(merged), .cw_out(new_cw));

  assign rd_next = wide_mode ? old_data[{bsel[2:1], 4'b0000} +: 16]
                             : {8'h00, old_data[{bsel, 3'b000} +: 8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (do_read) rd_q <= rd_next;
      if (~cs_n && hit) err_q <= 1'b1;
    end
  end

  assign dq_drive = ~cs_n & out_en;
  assign rdata    = dq_drive ? {wide_mode ? rd_q[15:8] : 8'h00, rd_q[7:0]} : 16'h0000;
  assign err_seen = err_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);                                               // R10
  AST_FLAG_SET_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (~cs_n && hit) |=> err_q);                                      // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(rd_q));                                        // R5
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!dq_drive && rdata == 16'h0000));                  // R6
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> rdata[15:8] == 8'h00);                           // R7
  AST_SINGLE_FIX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && int'(syn) <= CW_W) |-> cw_syndrome(fixed_cw) == '0);    // R8
endmodule

// File: tb/test_ecc_packed_mem.sv
module test_ecc_packed_mem;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_en, out_en, wide_mode, inj_en;
  logic [20:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        dq_drive, err_seen;
  logic [6:0]  inj_pos;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_packed_mem i_ecc_packed_mem (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .out_en(out_en),
    .wide_mode(wide_mode), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dq_drive(dq_drive), .err_seen(err_seen), .inj_en(inj_en), .inj_pos(inj_pos));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(logic c, logic w, logic o, logic [20:0] a, logic [15:0] d,
                     logic inj = 1'b0, logic [6:0] p = 7'd0);
    @(negedge clk);
    cs_n = c; wr_en = w; out_en = o; addr = a; wdata = d; inj_en = inj; inj_pos = p;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; wr_en = 1'b0; out_en = 1'b1; wide_mode = 1'b0;
    addr = '0; wdata = '0; inj_en = 1'b0; inj_pos = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [20:0] byte_addr(logic [20:0] base, int b);
    return base | (21'(b >> 2) << 20) | 21'(b & 3);
  endfunction

  task automatic t_reset();
    do_reset();
    cs_n = 1'b0; out_en = 1'b1;
    chk("R1 rdata after reset", rdata, 16'h0000);
    chk("R1 err_seen after reset", {15'b0, err_seen}, 16'h0000);
    wide_mode = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 21'h1F0ABC, 16'h0);
    chk("R1 array reads zero", rdata, 16'h0000);
    wide_mode = 1'b0;
  endtask

  task automatic t_bytes();
    for (int b = 0; b < 8; b++)
      cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000310, b), {8'hFF, 8'(8'h31 + b)});
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000310, b), 16'h0);
      chk($sformatf("R2 R7 byte %0d readback", b), rdata, {8'h00, 8'(8'h31 + b)});
    end
    cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000310, 5), 16'hAA77);
    cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000310, 4), 16'h0);
    chk("R2 neighbour byte kept", rdata, 16'h0035);
    cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000310, 5), 16'h0);
    chk("R7 upper wdata ignored", rdata, 16'h0077);
  endtask

  task automatic t_halves();
    wide_mode = 1'b1;
    for (int h = 0; h < 4; h++)
      cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000420, 2*h), 16'(16'hB0C0 + 16'h0101*h));
    for (int h = 0; h < 4; h++) begin
      cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000420, 2*h) | 21'h1, 16'h0);
      chk($sformatf("R3 halfword %0d, addr0 ignored", h), rdata, 16'(16'hB0C0 + 16'h0101*h));
    end
    wide_mode = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000420, 6), 16'h0);
    chk("R3 lane 3 low byte", rdata, 16'h00C3);
    cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000420, 7), 16'h0);
    chk("R3 lane 3 high byte", rdata, 16'h00B3);
  endtask

  task automatic t_latency_ce_oe();
    wide_mode = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 21'h000500, 16'h1234);
    cyc(1'b0, 1'b1, 1'b1, 21'h000504, 16'h5678);
    cyc(1'b0, 1'b0, 1'b1, 21'h000500, 16'h0);
    chk("R4 read visible after edge", rdata, 16'h1234);
    cyc(1'b0, 1'b1, 1'b1, 21'h000508, 16'h9999);
    chk("R4 held across write", rdata, 16'h1234);
    cyc(1'b1, 1'b1, 1'b1, 21'h000504, 16'hDEAD);
    chk("R5 disabled drives zero", {rdata[15:1], dq_drive}, 16'h0000);
    cyc(1'b0, 1'b0, 1'b0, 21'h000504, 16'h0);
    chk("R6 oe low quiet", {rdata[15:1], dq_drive}, 16'h0000);
    cyc(1'b0, 1'b1, 1'b1, 21'h00050C, 16'h4444);
    chk("R5 R6 held read, disabled write skipped", rdata, 16'h5678);
    wide_mode = 1'b0;
  endtask

  task automatic t_correct_read();
    int pos [12] = '{0, 1, 2, 3, 6, 7, 15, 31, 40, 63, 64, 70};
    do_reset();
    wide_mode = 1'b1;
    for (int h = 0; h < 4; h++)
      cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000640, 2*h), 16'(16'h5A00 + 16'h1111*h));
    foreach (pos[i]) begin
      cyc(1'b1, 1'b0, 1'b1, 21'h000640, 16'h0, 1'b1, 7'(pos[i]));
      if (i == 0) chk("R10 flip alone leaves flag clear", {15'b0, err_seen}, 16'h0000);
      cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000640, 2*(i % 4)), 16'h0);
      chk($sformatf("R8 R12 bit %0d corrected", pos[i]), rdata, 16'(16'h5A00 + 16'h1111*(i % 4)));
      cyc(1'b0, 1'b1, 1'b1, 21'h000640, 16'h5A00);
    end
    chk("R10 flag set by read", {15'b0, err_seen}, 16'h0001);
    cyc(1'b0, 1'b0, 1'b1, 21'h000640, 16'h0);
    chk("R10 flag stays set", {15'b0, err_seen}, 16'h0001);
    wide_mode = 1'b0;
  endtask

  task automatic t_write_into_bad_word();
    do_reset();
    for (int b = 0; b < 8; b++)
      cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000200, b), 16'(8'h90 + b));
    cyc(1'b1, 1'b0, 1'b1, 21'h000200, 16'h0, 1'b1, 7'd20);
    chk("R10 no flag before access", {15'b0, err_seen}, 16'h0000);
    cyc(1'b0, 1'b1, 1'b1, byte_addr(21'h000200, 3), 16'h00C3);
    chk("R9 R10 write sets flag", {15'b0, err_seen}, 16'h0001);
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 1'b0, 1'b1, byte_addr(21'h000200, b), 16'h0);
      chk($sformatf("R9 byte %0d after merge", b), rdata, (b == 3) ? 16'h00C3 : 16'(8'h90 + b));
    end
  endtask

  task automatic t_wrap();
    cyc(1'b0, 1'b1, 1'b1, 21'h000104, 16'h005A);
    cyc(1'b0, 1'b0, 1'b1, 21'h000904, 16'h0);
    chk("R11 row 9 aliases row 1", rdata, 16'h005A);
    cyc(1'b0, 1'b1, 1'b1, 21'h0F8104, 16'h00A5);
    cyc(1'b0, 1'b0, 1'b1, 21'h000104, 16'h0);
    chk("R11 high row bits ignored", rdata, 16'h00A5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bytes();
    t_halves();
    t_latency_ce_oe();
    t_correct_read();
    t_write_into_bad_word();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule